// File: doc/BRIEF.md
# AXI Reset-Window Protocol Monitor

A passive observer for one AXI4 port. It taps the port's active-low bus reset, the five channel valid signals and the burst and size fields of both address channels, and drives nothing back onto the bus. While the bus is held in reset, it flags any valid it sees high. Manager-side valids (write address, write data, read address) and subordinate-side valids (read data, write response) are reported separately. Once the bus is out of reset, it flags a reserved burst type or an oversized transfer on either address channel whenever that channel's valid is high.

Each error flag is sticky and survives bus reset edges in both directions, so a fault caught during the reset window can still be read once traffic has started. A synchronous clear input, or the monitor's own reset, wipes them. A 3-bit code keeps the identity of the first fault since the last clear. A registered status word mirrors the bus reset level and the five valid levels.

Top module: `axi_rst_chk`

## Requirements
- R1: If `bus_rst_ni` is low at a rising edge and any of `aw_valid_i`, `w_valid_i`, `ar_valid_i` is high, `mgr_err_o` is high from the next cycle.
- R2: If `bus_rst_ni` is low at a rising edge and `r_valid_i` or `b_valid_i` is high, `sub_err_o` is high from the next cycle.
- R3: With `bus_rst_ni` high, a burst field equal to 2'b11 on a channel whose valid (`aw_valid_i` or `ar_valid_i`) is high sets `burst_err_o` in the next cycle. Values 2'b00, 2'b01 and 2'b10 are legal.
- R4: With `bus_rst_ni` high and the channel valid high, a size code s sets `size_err_o` in the next cycle when 2**s exceeds `DATA_BYTES`. With the default of 4, codes 0 to 2 are legal and 3 to 7 are errors.
- R5: Burst and size fields are ignored while their channel valid is low, and also while `bus_rst_ni` is low. A valid seen during bus reset raises only `mgr_err_o` or `sub_err_o`.
- R6: The reset-window check uses the value of `bus_rst_ni` sampled at each rising edge. A valid high at the edge where the bus reset is released, with `bus_rst_ni` still low at that edge, is flagged.
- R7: All four error flags are sticky. Neither release nor reassertion of `bus_rst_ni` clears them.
- R8: `first_err_o` is 0 while no fault has been seen. The first fault sets it to 1 (manager valid in reset), 2 (subordinate valid in reset), 3 (reserved burst) or 4 (illegal size); the lowest code wins when faults coincide. The code then holds until cleared.
- R9: `status_o` is registered one cycle behind its inputs. Bit 0 is `bus_rst_ni`, bits 1 to 5 are `aw_valid_i`, `w_valid_i`, `ar_valid_i`, `r_valid_i` and `b_valid_i`.
- R10: `clr_i` high at an edge zeroes all flags and `first_err_o` in the next cycle. Faults seen at that same edge are dropped.
- R11: `rst_ni` low clears all flags, `first_err_o` and `status_o` asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Monitor reset, active low, asynchronous |
| clr_i | input | 1 | Synchronous clear of flags and first-error code |
| bus_rst_ni | input | 1 | Observed bus reset, active low |
| aw_valid_i | input | 1 | Write address valid |
| aw_burst_i | input | 2 | Write address burst type |
| aw_size_i | input | 3 | Write address size code |
| w_valid_i | input | 1 | Write data valid |
| ar_valid_i | input | 1 | Read address valid |
| ar_burst_i | input | 2 | Read address burst type |
| ar_size_i | input | 3 | Read address size code |
| r_valid_i | input | 1 | Read data valid |
| b_valid_i | input | 1 | Write response valid |
| mgr_err_o | output | 1 | Sticky: manager valid seen in reset |
| sub_err_o | output | 1 | Sticky: subordinate valid seen in reset |
| burst_err_o | output | 1 | Sticky: reserved burst type |
| size_err_o | output | 1 | Sticky: size wider than bus |
| first_err_o | output | 3 | Code of first fault since clear |
| status_o | output | 6 | Registered reset and valid levels |

## Verification
Each of the five valids is raised alone inside the reset window. This tells the manager group apart from the subordinate group, and each time the address fields carry poisoned values, so the reset-gating of the field checks is tested as well. After release, every burst and size code is swept on each address channel, with valid both high and low and with garbage on the idle channel. This separates the burst rule from the size rule, the working channel from the idle one, and the priority of the first-error code. All 64 status patterns are applied. Targeted sequences cover the release edge, coinciding faults, a clear that coincides with a fault, stickiness across bus reset edges, and monitor reset.

// File: rtl/axi_rst_chk_pkg.sv
package axi_rst_chk_pkg;
  localparam int NUM_ERR   = 4;
  localparam int NUM_VLD   = 5;
  localparam int CODE_W    = 3;
  localparam logic [1:0] BURST_RSVD = 2'b11;

  typedef enum logic [CODE_W-1:0] {
    ERR_NONE    = 3'd0,
    ERR_MGR_RST = 3'd1,
    ERR_SUB_RST = 3'd2,
    ERR_BURST   = 3'd3,
    ERR_SIZE    = 3'd4
  } err_code_e;

  // event vector bit positions, ascending = descending priority
  localparam int EV_MGR   = 0;
  localparam int EV_SUB   = 1;
  localparam int EV_BURST = 2;
  localparam int EV_SIZE  = 3;
endpackage

// File: rtl/rst_valid_mon.sv
module rst_valid_mon #(
  parameter int NUM_VLD = 3
) (
  input  logic               bus_rst_ni,
  input  logic [NUM_VLD-1:0] valid_i,
  output logic               hit_o
);
  assign hit_o = !bus_rst_ni && (|valid_i);
endmodule

// File: rtl/addr_field_chk.sv
module addr_field_chk #(
  parameter int DATA_BYTES = 4
) (
  input  logic       bus_rst_ni,
  input  logic       valid_i,
  input  logic [1:0] burst_i,
  input  logic [2:0] size_i,
  output logic       burst_bad_o,
  output logic       size_bad_o
);
  import axi_rst_chk_pkg::*;

  localparam logic [31:0] BUS_BYTES = 32'(DATA_BYTES);

  logic live;
  logic [31:0] xfer_bytes;

  assign live        = bus_rst_ni && valid_i;
  assign xfer_bytes  = 32'd1 << size_i;
  assign burst_bad_o = live && (burst_i == BURST_RSVD);
  assign size_bad_o  = live && (xfer_bytes > BUS_BYTES);
endmodule

// File: rtl/err_log.sv
module err_log
  import axi_rst_chk_pkg::*;
#(
  parameter int N = NUM_ERR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [N-1:0]      ev_i,
  output logic [N-1:0]      flag_o,
  output logic [CODE_W-1:0] code_o
);
  logic [N-1:0]      flag_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ev_i[i]) pick = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      code_q <= ERR_NONE;
    end else if (clr_i) begin
      flag_q <= '0;
      code_q <= ERR_NONE;
    end else begin
      flag_q <= flag_q | ev_i;
      if (code_q == ERR_NONE) code_q <= pick;
    end
  end

  assign flag_o = flag_q;
  assign code_o = code_q;

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flag_o == '0 && code_o == ERR_NONE));

  p_code_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != ERR_NONE && !clr_i) |=> $stable(code_o));

  p_code_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == ERR_NONE && !clr_i && ev_i[0]) |=> code_o == ERR_MGR_RST);

  p_code_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= CODE_W'(N));
endmodule

// File: rtl/axi_rst_chk.sv
module axi_rst_chk
  import axi_rst_chk_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        bus_rst_ni,
  input  logic        aw_valid_i,
  input  logic [1:0]  aw_burst_i,
  input  logic [2:0]  aw_size_i,
  input  logic        w_valid_i,
  input  logic        ar_valid_i,
  input  logic [1:0]  ar_burst_i,
  input  logic [2:0]  ar_size_i,
  input  logic        r_valid_i,
  input  logic        b_valid_i,
  output logic        mgr_err_o,
  output logic        sub_err_o,
  output logic        burst_err_o,
  output logic        size_err_o,
  output logic [2:0]  first_err_o,
  output logic [5:0]  status_o
);
  localparam int NUM_ACH = 2;
  localparam int ST_W    = NUM_VLD + 1;

  logic [NUM_ACH-1:0] ach_vld, burst_bad, size_bad;
  logic [NUM_ACH-1:0][1:0] ach_burst;
  logic [NUM_ACH-1:0][2:0] ach_size;
  logic mgr_hit, sub_hit;
  logic [NUM_ERR-1:0] ev, flag;
  logic [ST_W-1:0] snap, status_q;

  assign ach_vld   = {ar_valid_i, aw_valid_i};
  assign ach_burst = {ar_burst_i, aw_burst_i};
  assign ach_size  = {ar_size_i,  aw_size_i};

  rst_valid_mon #(.NUM_VLD(3)) u_mgr_mon (
    .bus_rst_ni (bus_rst_ni),
    .valid_i    ({ar_valid_i, w_valid_i, aw_valid_i}),
    .hit_o      (mgr_hit)
  );

  rst_valid_mon #(.NUM_VLD(2)) u_sub_mon (
    .bus_rst_ni (bus_rst_ni),
    .valid_i    ({b_valid_i, r_valid_i}),
    .hit_o      (sub_hit)
  );

  for (genvar c = 0; c < NUM_ACH; c++) begin : g_ach
    addr_field_chk #(.DATA_BYTES(DATA_BYTES)) u_fld (
      .bus_rst_ni  (bus_rst_ni),
      .valid_i     (ach_vld[c]),
      .burst_i     (ach_burst[c]),
      .size_i      (ach_size[c]),
      .burst_bad_o (burst_bad[c]),
      .size_bad_o  (size_bad[c])
    );
  end

  always_comb begin
    ev = '0;
    ev[EV_MGR]   = mgr_hit;
    ev[EV_SUB]   = sub_hit;
    ev[EV_BURST] = |burst_bad;
    ev[EV_SIZE]  = |size_bad;
  end

  err_log #(.N(NUM_ERR)) u_log (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .ev_i   (ev),
    .flag_o (flag),
    .code_o (first_err_o)
  );

  assign snap = {b_valid_i, r_valid_i, ar_valid_i, w_valid_i, aw_valid_i, bus_rst_ni};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= snap;
  end

  assign status_o    = status_q;
  assign mgr_err_o   = flag[EV_MGR];
  assign sub_err_o   = flag[EV_SUB];
  assign burst_err_o = flag[EV_BURST];
  assign size_err_o  = flag[EV_SIZE];

  p_mgr_in_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rst_ni && (aw_valid_i || w_valid_i || ar_valid_i) && !clr_i) |=> mgr_err_o);

  p_sub_in_rst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rst_ni && (r_valid_i || b_valid_i) && !clr_i) |=> sub_err_o);

  p_rsvd_burst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_ni && !clr_i && ((aw_valid_i && aw_burst_i == 2'b11) ||
                              (ar_valid_i && ar_burst_i == 2'b11))) |=> burst_err_o);

  p_field_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rst_ni && !burst_err_o && !size_err_o) |=> (!burst_err_o && !size_err_o));

  p_size_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_ni && !clr_i && aw_valid_i && ((32'd1 << aw_size_i) > 32'(DATA_BYTES)))
      |=> size_err_o);

  p_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> status_o == $past(snap));
endmodule

// File: tb/tb_axi_rst_chk.sv
`timescale 1ns/1ps
module tb_axi_rst_chk;
  logic clk = 1'b0;
  logic rst_ni = 1'b0, clr = 1'b0, bus_rst_n = 1'b0;
  logic aw_v = 0, w_v = 0, ar_v = 0, r_v = 0, b_v = 0;
  logic [1:0] aw_b = 0, ar_b = 0;
  logic [2:0] aw_s = 0, ar_s = 0;
  logic mgr_e, sub_e, bur_e, siz_e;
  logic [2:0] code;
  logic [5:0] stat;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  axi_rst_chk dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .bus_rst_ni(bus_rst_n),
    .aw_valid_i(aw_v), .aw_burst_i(aw_b), .aw_size_i(aw_s), .w_valid_i(w_v),
    .ar_valid_i(ar_v), .ar_burst_i(ar_b), .ar_size_i(ar_s),
    .r_valid_i(r_v), .b_valid_i(b_v),
    .mgr_err_o(mgr_e), .sub_err_o(sub_e), .burst_err_o(bur_e), .size_err_o(siz_e),
    .first_err_o(code), .status_o(stat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic flags(input string tag, input int m, s, b, z, c);
    chk({tag, " mgr"}, int'(mgr_e), m);
    chk({tag, " sub"}, int'(sub_e), s);
    chk({tag, " burst"}, int'(bur_e), b);
    chk({tag, " size"}, int'(siz_e), z);
    chk({tag, " code"}, int'(code), c);
  endtask

  task automatic idle();
    {aw_v, w_v, ar_v, r_v, b_v} = '0;
  endtask

  task automatic do_clear();
    @(negedge clk); idle(); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    flags("R11 reset state", 0, 0, 0, 0, 0);
    chk("R11 status reset", int'(stat), 0);

    // R1/R2/R5: each valid alone in bus reset, with poisoned address fields
    for (int v = 0; v < 5; v++) begin
      @(negedge clk);
      bus_rst_n = 0;
      aw_b = 2'b11; aw_s = 3'd7; ar_b = 2'b11; ar_s = 3'd7;
      {b_v, r_v, ar_v, w_v, aw_v} = 5'(1 << v);
      @(negedge clk); idle();
      if (v < 3) flags("R1 mgr valid in reset", 1, 0, 0, 0, 1);
      else       flags("R2 sub valid in reset", 0, 1, 0, 0, 2);
      bus_rst_n = 1;
      repeat (2) @(negedge clk);
      chk("R7 survives release", int'(mgr_e | sub_e), 1);
      bus_rst_n = 0;
      @(negedge clk);
      chk("R7 survives reassert", int'(mgr_e | sub_e), 1);
      do_clear();
      flags("R10 clear", 0, 0, 0, 0, 0);
    end

    // R6: valid high at the release edge
    @(negedge clk); bus_rst_n = 0; aw_v = 1;
    @(posedge clk); #1 bus_rst_n = 1; aw_v = 0;
    @(negedge clk);
    flags("R6 release edge", 1, 0, 0, 0, 1);
    do_clear();
    // valid rising together with release is not a reset fault
    @(negedge clk); bus_rst_n = 0;
    @(posedge clk); #1 bus_rst_n = 1; w_v = 1;
    @(negedge clk); idle();
    @(negedge clk);
    flags("R6 after release", 0, 0, 0, 0, 0);

    // R3/R4/R5/R8: full sweep of burst and size on each address channel
    for (int ch = 0; ch < 2; ch++)
      for (int bt = 0; bt < 4; bt++)
        for (int sz = 0; sz < 8; sz++)
          for (int vl = 0; vl < 2; vl++) begin
            int eb, es, ec;
            eb = (vl == 1 && bt == 3) ? 1 : 0;
            es = (vl == 1 && (1 << sz) > 4) ? 1 : 0;
            ec = eb ? 3 : (es ? 4 : 0);
            @(negedge clk);
            if (ch == 0) begin
              aw_v = 1'(vl); aw_b = 2'(bt); aw_s = 3'(sz); ar_b = 2'b11; ar_s = 3'd7;
            end else begin
              ar_v = 1'(vl); ar_b = 2'(bt); ar_s = 3'(sz); aw_b = 2'b11; aw_s = 3'd7;
            end
            @(negedge clk); idle();
            chk("R3 burst sweep", int'(bur_e), eb);
            chk("R4 size sweep", int'(siz_e), es);
            chk("R8 code sweep", int'(code), ec);
            chk("R5 no reset flag", int'(mgr_e | sub_e), 0);
            do_clear();
          end

    // R8: simultaneous faults, then a later one
    @(negedge clk); bus_rst_n = 0; b_v = 1; w_v = 1;
    @(negedge clk); idle(); bus_rst_n = 1;
    flags("R8 coincide", 1, 1, 0, 0, 1);
    ar_v = 1; ar_b = 2'b11; ar_s = 3'd5;
    @(negedge clk); idle();
    flags("R8 later fault", 1, 1, 1, 1, 1);
    do_clear();
    @(negedge clk); aw_v = 1; aw_b = 2'b11; aw_s = 3'd6;
    @(negedge clk); idle();
    chk("R8 burst beats size", int'(code), 3);
    do_clear();

    // R10: clear and fault in the same cycle
    @(negedge clk); ar_v = 1; ar_b = 2'b11; clr = 1;
    @(negedge clk); idle(); clr = 0;
    flags("R10 clear wins", 0, 0, 0, 0, 0);

    // R9: status over all 64 patterns
    for (int p = 0; p < 64; p++) begin
      @(negedge clk);
      bus_rst_n = p[0];
      {b_v, r_v, ar_v, w_v, aw_v} = 5'(p >> 1);
      aw_b = 0; ar_b = 0; aw_s = 0; ar_s = 0;
      @(negedge clk);
      chk("R9 status", int'(stat), p);
    end
    idle(); bus_rst_n = 1;

    // R11: monitor reset clears everything
    @(negedge clk); bus_rst_n = 0; r_v = 1;
    @(negedge clk); idle(); bus_rst_n = 1;
    chk("R11 pre", int'(sub_e), 1);
    #1 rst_ni = 0;
    #1 flags("R11 async clear", 0, 0, 0, 0, 0);
    chk("R11 status clear", int'(stat), 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule